// File: doc/BRIEF.md
# Write Target Ready Controller

This block drives the target-ready line of a memory-controller target agent. It covers ordinary writes, reads that hit a modified line in another agent's cache, and writes that hit a modified line. A request strobe starts each transaction, and a flag tells a write from a read. The block then waits for three things before it asserts ready: the minimum spacing after the request, the completion of the previous transaction's response, and a free buffer of the right size. The snoop result decides whether a further ready for a full-line writeback is needed.

The length of each ready pulse follows the data-busy line that the block samples while ready is high. A handshake completes in the first ready cycle that sees busy low. In the next clock ready drops and a one-cycle done pulse reports the handshake to the response sequencer. A side flag tells the requester-data handshake apart from the line-writeback handshake. On a write that hits a modified line, ready is raised twice. The first handshake takes the requester's data into a small buffer. After at least one low cycle, ready rises again to take the snooper's full line into a line buffer.

All inputs are sampled on the rising clock edge and all outputs are registered. Only one transaction is tracked at a time.

Top module: `wr_target_ready`

## Requirements
- R1: During and right after reset, trdyOut, hsDone and hsLine are all 0.
- R2: If reqValid is accepted in cycle c, the first ready goes high no earlier than cycle c+3. It does go high in c+3 when every other condition already holds.
- R3: Ready for a write's data, or for a read hit's line, rises only in the cycle after a cycle in which prevRespDone (a level: the previous response has been driven) was 1.
- R4: The first ready of a write rises only in the cycle after bufSmallFree was 1. A line-writeback ready rises only in the cycle after bufLineFree was 1.
- R5: If busyIn is 0 in a cycle where trdyOut is 1, trdyOut is 0 in the next cycle.
- R6: While trdyOut is 1 and busyIn is 1, trdyOut stays 1. It drops in the cycle after the first ready cycle with busyIn at 0.
- R7: hsDone is a one-cycle pulse in the cycle after each completed handshake, and trdyOut is 0 in that cycle. hsLine is 1 with it for a line-writeback handshake and 0 for a requester-data handshake.
- R8: A write whose snoop result (snoopValid with snoopHitMod=1) reports a modified hit gets a second ready. It is raised once the first handshake is done, ready has been low for at least one cycle, and bufLineFree is 1. This holds whether the snoop result arrives before or after the first handshake. A write that misses gets exactly one ready.
- R9: A read that misses gets no ready and no done pulse. A read that hits gets one line-writeback ready under the R2, R3 and R4 rules.
- R10: A snoop hit that arrives in the same cycle as the first handshake of a write is honoured. The second ready rises in the cycle right after the done pulse.
- R11: A reqValid pulse while a transaction is in progress is ignored. It causes no further ready once that transaction ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe of a transaction targeting this agent |
| reqWrite | input | 1 | 1 = write, 0 = read, qualified by reqValid |
| snoopValid | input | 1 | Snoop result valid for the current transaction |
| snoopHitMod | input | 1 | Snoop result reports a hit on a modified line |
| bufSmallFree | input | 1 | Buffer for a write's data (up to 32 bytes) is free |
| bufLineFree | input | 1 | Buffer for a full 64-byte line is free |
| busyIn | input | 1 | Sampled data-busy line |
| prevRespDone | input | 1 | Previous transaction's response has been driven (level) |
| trdyOut | output | 1 | Target-ready |
| hsDone | output | 1 | One-cycle pulse: ready handshake satisfied |
| hsLine | output | 1 | With hsDone: 1 = line-writeback handshake, 0 = requester data |

## Verification
On a write, the snoop result can arrive in the same cycle in which the first ready handshake completes. One function is closing the first handshake; the other is capturing the snoop verdict that decides on a second ready. The bench provokes this by holding back the snoop result until the first ready cycle, then driving snoopValid with a hit while busyIn is low in that same cycle. It expects the done pulse with hsLine at 0 in the next cycle, ready high in the cycle after that, and a line done pulse once that ready sees busy low.

// File: rtl/wtr_pkg.sv
package wtr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_REQ,
    ST_READY_REQ,
    ST_WAIT_LINE,
    ST_READY_LINE,
    ST_WAIT_SNOOP
  } wtrState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic ageStart;   // new transaction accepted
    logic raise;      // set ready at next edge
    logic raiseLine;  // the raised ready is for a full-line writeback
  } wtrStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic ageOk;      // request spacing satisfied
    logic snpKnown;   // snoop result captured or arriving now
    logic snpHit;     // snoop result is a modified hit
    logic hsNow;      // ready high and busy low this cycle
  } wtrStatus_t;

endpackage

// File: rtl/wtr_datapath.sv
module wtr_datapath
  import wtr_pkg::*;
#(
  parameter int MIN_REQ_GAP = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  wtrStrobe_t strobe,
  input  logic       busyIn,
  input  logic       snoopValid,
  input  logic       snoopHitMod,
  input  logic       prevRespDone,
  input  logic       bufSmallFree,
  input  logic       bufLineFree,
  output wtrStatus_t status,
  output logic       trdyOut,
  output logic       hsDone,
  output logic       hsLine
);

  localparam int AGE_MAX = MIN_REQ_GAP - 1;
  localparam int AGE_W   = $clog2(MIN_REQ_GAP + 1);

  logic [AGE_W-1:0] ageQ;
  logic             snpKnownQ;
  logic             snpHitQ;
  logic             trdyQ;
  logic             doneQ;
  logic             lineQ;
  logic             hsLineQ;
  logic             handshake;

  // request age counter, saturating at the spacing limit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ageQ <= '0;
    end else if (strobe.ageStart) begin
      ageQ <= AGE_W'(1);
    end else if (ageQ < AGE_W'(AGE_MAX)) begin
      ageQ <= ageQ + AGE_W'(1);
    end
  end

  // snoop verdict capture, cleared by each accepted request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      snpKnownQ <= 1'b0;
      snpHitQ   <= 1'b0;
    end else if (strobe.ageStart) begin
      snpKnownQ <= 1'b0;
      snpHitQ   <= 1'b0;
    end else if (snoopValid) begin
      snpKnownQ <= 1'b1;
      snpHitQ   <= snoopHitMod;
    end
  end

  assign handshake = trdyQ & ~busyIn;

  // ready, done and handshake kind
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trdyQ   <= 1'b0;
      doneQ   <= 1'b0;
      lineQ   <= 1'b0;
      hsLineQ <= 1'b0;
    end else begin
      trdyQ   <= strobe.raise | (trdyQ & busyIn);
      doneQ   <= handshake;
      hsLineQ <= handshake & lineQ;
      if (strobe.raise) begin
        lineQ <= strobe.raiseLine;
      end
    end
  end

  always_comb begin
    status.ageOk    = (ageQ >= AGE_W'(AGE_MAX));
    status.snpKnown = snpKnownQ | snoopValid;
    status.snpHit   = snpKnownQ ? snpHitQ : snoopHitMod;
    status.hsNow    = handshake;
  end

  assign trdyOut = trdyQ;
  assign hsDone  = doneQ;
  assign hsLine  = hsLineQ;

  a_r2_req_spacing: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trdyQ) |-> $past(ageQ >= AGE_W'(AGE_MAX)));

  a_r3_prev_resp: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(trdyQ) && !lineQ) |-> $past(prevRespDone));

  a_r4_small_buf: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(trdyQ) && !lineQ) |-> $past(bufSmallFree));

  a_r4_line_buf: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(trdyQ) && lineQ) |-> $past(bufLineFree));

  a_r5_single_drop: assert property (@(posedge clk) disable iff (!rstN)
    (trdyOut && !busyIn) |=> (!trdyOut && hsDone));

  a_r6_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    (trdyOut && busyIn) |=> trdyOut);

  a_r7_done_low: assert property (@(posedge clk) disable iff (!rstN)
    hsDone |-> !trdyOut);

  a_r7_line_flag: assert property (@(posedge clk) disable iff (!rstN)
    hsLine |-> hsDone);

endmodule

// File: rtl/wtr_ctrl.sv
module wtr_ctrl
  import wtr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       prevRespDone,
  input  logic       bufSmallFree,
  input  logic       bufLineFree,
  input  wtrStatus_t status,
  output wtrStrobe_t strobe
);

  wtrState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.ageStart = 1'b1;
          stateD = reqWrite ? ST_WAIT_REQ : ST_WAIT_SNOOP;
        end
      end
      ST_WAIT_REQ: begin
        if (status.ageOk && prevRespDone && bufSmallFree) begin
          strobe.raise = 1'b1;
          stateD = ST_READY_REQ;
        end
      end
      ST_READY_REQ: begin
        if (status.hsNow) begin
          stateD = (status.snpKnown && !status.snpHit) ? ST_IDLE : ST_WAIT_LINE;
        end
      end
      ST_WAIT_LINE: begin
        if (status.snpKnown) begin
          if (!status.snpHit) begin
            stateD = ST_IDLE;
          end else if (bufLineFree) begin
            strobe.raise     = 1'b1;
            strobe.raiseLine = 1'b1;
            stateD = ST_READY_LINE;
          end
        end
      end
      ST_READY_LINE: begin
        if (status.hsNow) begin
          stateD = ST_IDLE;
        end
      end
      ST_WAIT_SNOOP: begin
        if (status.snpKnown) begin
          if (!status.snpHit) begin
            stateD = ST_IDLE;
          end else if (status.ageOk && prevRespDone && bufLineFree) begin
            strobe.raise     = 1'b1;
            strobe.raiseLine = 1'b1;
            stateD = ST_READY_LINE;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  // R8/R9: a line writeback ready is only raised on a known modified hit
  a_r8_line_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.raiseLine |-> (status.snpKnown && status.snpHit));

  // R11: a new transaction is only accepted from the idle state
  a_r11_one_at_a_time: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ageStart |=> (stateQ == ST_WAIT_REQ || stateQ == ST_WAIT_SNOOP));

endmodule

// File: rtl/wr_target_ready.sv
module wr_target_ready
  import wtr_pkg::*;
#(
  parameter int MIN_REQ_GAP = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqWrite,
  input  logic snoopValid,
  input  logic snoopHitMod,
  input  logic bufSmallFree,
  input  logic bufLineFree,
  input  logic busyIn,
  input  logic prevRespDone,
  output logic trdyOut,
  output logic hsDone,
  output logic hsLine
);

  wtrStrobe_t strobe;
  wtrStatus_t status;

  wtr_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .prevRespDone (prevRespDone),
    .bufSmallFree (bufSmallFree),
    .bufLineFree  (bufLineFree),
    .status       (status),
    .strobe       (strobe)
  );

  wtr_datapath #(
    .MIN_REQ_GAP (MIN_REQ_GAP)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .busyIn       (busyIn),
    .snoopValid   (snoopValid),
    .snoopHitMod  (snoopHitMod),
    .prevRespDone (prevRespDone),
    .bufSmallFree (bufSmallFree),
    .bufLineFree  (bufLineFree),
    .status       (status),
    .trdyOut      (trdyOut),
    .hsDone       (hsDone),
    .hsLine       (hsLine)
  );

endmodule

// File: tb/wr_target_ready_tb.sv
module wr_target_ready_tb_top;

  logic clk = 1'b0;
  logic rstN;
  logic reqValid, reqWrite, snoopValid, snoopHitMod;
  logic bufSmallFree, bufLineFree, busyIn, prevRespDone;
  logic trdyOut, hsDone, hsLine;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  wr_target_ready dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .snoopValid   (snoopValid),
    .snoopHitMod  (snoopHitMod),
    .bufSmallFree (bufSmallFree),
    .bufLineFree  (bufLineFree),
    .busyIn       (busyIn),
    .prevRespDone (prevRespDone),
    .trdyOut      (trdyOut),
    .hsDone       (hsDone),
    .hsLine       (hsLine)
  );

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  // move to the next sampling point (falling edge); outputs there belong to the new cycle
  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic defaults();
    reqValid = 0; reqWrite = 0; snoopValid = 0; snoopHitMod = 0;
    bufSmallFree = 1; bufLineFree = 1; busyIn = 0; prevRespDone = 1;
  endtask

  task automatic startReq(input logic wr);
    reqValid = 1; reqWrite = wr;
    cyc();
    reqValid = 0;
  endtask

  task automatic snoopPulse(input logic hit);
    snoopValid = 1; snoopHitMod = hit;
    cyc();
    snoopValid = 0; snoopHitMod = 0;
  endtask

  task automatic quiet(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      chk(trdyOut, 1'b0, req, "no ready expected");
      chk(hsDone, 1'b0, req, "no done expected");
      cyc();
    end
  endtask

  task automatic testReset();
    defaults();
    rstN = 0;
    cyc(3);
    chk(trdyOut, 1'b0, "R1", "trdy in reset");
    chk(hsDone, 1'b0, "R1", "done in reset");
    chk(hsLine, 1'b0, "R1", "line in reset");
    rstN = 1;
    cyc();
    chk(trdyOut, 1'b0, "R1", "trdy after reset");
    chk(hsDone, 1'b0, "R1", "done after reset");
  endtask

  task automatic testPlainWrite();
    startReq(1'b1);                       // now cycle 1
    chk(trdyOut, 1'b0, "R2", "c1 early");
    cyc();                                // c2
    chk(trdyOut, 1'b0, "R2", "c2 early");
    snoopPulse(1'b0);                     // c3
    chk(trdyOut, 1'b1, "R2", "ready at c3");
    cyc();                                // c4
    chk(trdyOut, 1'b0, "R5", "single-cycle ready");
    chk(hsDone, 1'b1, "R7", "done pulse");
    chk(hsLine, 1'b0, "R7", "requester handshake");
    cyc();
    quiet("R8", 5);                       // miss: only one ready
  endtask

  task automatic testBusyHold();
    startReq(1'b1);                       // c1
    snoopPulse(1'b0);                     // c2
    cyc();                                // c3
    chk(trdyOut, 1'b1, "R6", "ready c3");
    busyIn = 1;
    cyc();                                // c4
    chk(trdyOut, 1'b1, "R6", "held while busy c4");
    chk(hsDone, 1'b0, "R6", "no done while busy");
    cyc();                                // c5
    chk(trdyOut, 1'b1, "R6", "held while busy c5");
    busyIn = 0;
    cyc();                                // c6
    chk(trdyOut, 1'b0, "R6", "drop after busy low");
    chk(hsDone, 1'b1, "R7", "done after busy low");
    cyc();
    quiet("R6", 3);
  endtask

  task automatic testSmallBuffer();
    bufSmallFree = 0;
    startReq(1'b1);                       // c1
    snoopPulse(1'b0);                     // c2
    cyc();                                // c3
    chk(trdyOut, 1'b0, "R4", "no buffer c3");
    cyc();                                // c4
    chk(trdyOut, 1'b0, "R4", "no buffer c4");
    bufSmallFree = 1;
    cyc();                                // c5
    chk(trdyOut, 1'b1, "R4", "ready after buffer free");
    cyc();                                // c6
    chk(hsDone, 1'b1, "R4", "done after buffer case");
    cyc();
    quiet("R4", 3);
  endtask

  task automatic testPrevResp();
    prevRespDone = 0;
    startReq(1'b1);                       // c1
    snoopPulse(1'b0);                     // c2
    cyc();                                // c3
    chk(trdyOut, 1'b0, "R3", "prev response pending c3");
    cyc();                                // c4
    chk(trdyOut, 1'b0, "R3", "prev response pending c4");
    prevRespDone = 1;
    cyc();                                // c5
    chk(trdyOut, 1'b1, "R3", "ready cycle after response");
    cyc();
    chk(hsDone, 1'b1, "R3", "done after response case");
    cyc();
    quiet("R3", 3);
  endtask

  task automatic testWriteHitLateBuffer();
    bufLineFree = 0;
    startReq(1'b1);                       // c1
    snoopPulse(1'b1);                     // c2
    cyc();                                // c3
    chk(trdyOut, 1'b1, "R8", "first ready");
    cyc();                                // c4
    chk(trdyOut, 1'b0, "R8", "gap c4");
    chk(hsDone, 1'b1, "R7", "first done");
    chk(hsLine, 1'b0, "R7", "first done is requester");
    cyc();                                // c5
    chk(trdyOut, 1'b0, "R4", "line buffer busy c5");
    reqValid = 1; reqWrite = 1;           // stray strobe, must be ignored
    cyc();                                // c6
    reqValid = 0;
    chk(trdyOut, 1'b0, "R4", "line buffer busy c6");
    bufLineFree = 1;
    cyc();                                // c7
    chk(trdyOut, 1'b1, "R8", "second ready");
    cyc();                                // c8
    chk(trdyOut, 1'b0, "R8", "second drop");
    chk(hsDone, 1'b1, "R7", "second done");
    chk(hsLine, 1'b1, "R7", "second done is line");
    cyc();
    quiet("R11", 6);
  endtask

  task automatic testSameCycleSnoop();
    startReq(1'b1);                       // c1
    cyc(2);                               // c3
    chk(trdyOut, 1'b1, "R10", "first ready");
    snoopValid = 1; snoopHitMod = 1; busyIn = 0;
    cyc();                                // c4
    snoopValid = 0; snoopHitMod = 0;
    chk(trdyOut, 1'b0, "R10", "gap after first");
    chk(hsDone, 1'b1, "R10", "first done");
    chk(hsLine, 1'b0, "R10", "first done requester");
    cyc();                                // c5
    chk(trdyOut, 1'b1, "R10", "second ready right after done");
    cyc();                                // c6
    chk(hsDone, 1'b1, "R10", "second done");
    chk(hsLine, 1'b1, "R10", "second done line");
    cyc();
    quiet("R10", 3);
  endtask

  task automatic testWriteHitLateSnoop();
    startReq(1'b1);                       // c1
    cyc(2);                               // c3
    chk(trdyOut, 1'b1, "R8", "first ready late snoop");
    cyc();                                // c4
    chk(hsDone, 1'b1, "R8", "first done late snoop");
    cyc();                                // c5
    chk(trdyOut, 1'b0, "R8", "waiting for snoop c5");
    cyc();                                // c6
    chk(trdyOut, 1'b0, "R8", "waiting for snoop c6");
    snoopPulse(1'b1);                     // c7
    chk(trdyOut, 1'b1, "R8", "second ready after late hit");
    cyc();                                // c8
    chk(hsLine, 1'b1, "R8", "line done after late hit");
    cyc();
    quiet("R8", 3);
  endtask

  task automatic testReadMiss();
    startReq(1'b0);                       // c1
    snoopPulse(1'b0);                     // c2
    quiet("R9", 7);
  endtask

  task automatic testReadHit();
    startReq(1'b0);                       // c1
    snoopPulse(1'b1);                     // c2
    chk(trdyOut, 1'b0, "R9", "read hit early c2");
    cyc();                                // c3
    chk(trdyOut, 1'b1, "R9", "read hit ready c3");
    busyIn = 1;
    cyc();                                // c4
    chk(trdyOut, 1'b1, "R6", "read hit held");
    busyIn = 0;
    cyc();                                // c5
    chk(trdyOut, 1'b0, "R9", "read hit drop");
    chk(hsDone, 1'b1, "R9", "read hit done");
    chk(hsLine, 1'b1, "R9", "read hit is line");
    cyc();
    quiet("R9", 3);
  endtask

  initial begin
    #1_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    defaults();
    rstN = 0;
    cyc();
    testReset();
    cyc(2);
    testPlainWrite();        defaults(); cyc(2);
    testBusyHold();          defaults(); cyc(2);
    testSmallBuffer();       defaults(); cyc(2);
    testPrevResp();          defaults(); cyc(2);
    testWriteHitLateBuffer(); defaults(); cyc(2);
    testSameCycleSnoop();    defaults(); cyc(2);
    testWriteHitLateSnoop(); defaults(); cyc(2);
    testReadMiss();          defaults(); cyc(2);
    testReadHit();           defaults(); cyc(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule